// File: doc/BRIEF.md
# Link Low-Power Entry Handshake Controller

This block runs the link-layer exchange that moves a serial link into one of two low-power interface states: a shallow state with quick recovery and a deep state that saves more power. Either end of the link may start the exchange. When the local upper layers ask for a state, the block acts as initiator. It has the PHY send the matching request primitive on every cycle until the far end answers with an accept or a reject. A timer can cut the attempt short. When a request primitive arrives from the far end, the block acts as responder. It reports the request upward, waits for the upper layers to decide, and then sends the accept or reject primitive for a fixed number of cycles. That count is a parameter and must lie between 4 and 16.

Once the link is accepted into a low-power state, the block shows that state to the PHY and stays there until the wake logic pulses `lp_exit`. The far-end interface is a primitive strobe with a 3-bit code in each direction. The codes are 1 for a shallow request, 2 for a deep request, 3 for accept and 4 for reject.

Top module: `lpm_handshake`

## Requirements
- R1: After reset, `tx_valid` is 0, `lp_state` is 0 (active), and `up_granted`, `up_rejected`, `up_timeout` and `up_ind_valid` are all 0.
- R2: When the block is idle and `up_req_valid` is sampled high, `tx_valid` is 1 from the next cycle onward. On every such cycle `tx_prim` carries code 1 if `up_req_deep` was 0, or code 2 if it was 1.
- R3: If a reply (code 3 or 4) is sampled on `rx_valid`/`rx_prim` while the block is sending a request, `tx_valid` is 0 in the following cycle.
- R4: An accept (code 3) ends the request. In the next cycle `up_granted` pulses for exactly one cycle, and `lp_state` changes to 1 for a shallow request or 2 for a deep one.
- R5: A reject (code 4) ends the request. In the next cycle `up_rejected` pulses for one cycle, `lp_state` stays 0 and the block is idle again.
- R6: With `TIMEOUT_CYCLES` > 0, if no reply arrives after `TIMEOUT_CYCLES` request cycles, the block stops transmitting. In the next cycle `up_timeout` pulses for one cycle and the block returns to idle.
- R7: When the block is idle and a request primitive (code 1 or 2) is received, `up_ind_valid` pulses for one cycle in the next cycle, and `up_ind_deep` shows which state was asked for. Repeated request primitives that follow do not pulse it again.
- R8: In the cycle after `up_dec_valid`, the responder starts sending code 3 (if `up_dec_accept` is 1) or code 4 (if it is 0). It sends it on exactly `REPLY_COUNT` consecutive cycles.
- R9: When an accepting reply ends, `lp_state` shows the requested state (1 or 2). When a rejecting reply ends, `lp_state` stays 0.
- R10: While a handshake is in progress or the link is in low power, `up_req_valid` and received request primitives are ignored. The code being sent does not change, no indication is raised, and no transmission starts.
- R11: In a low-power state, a pulse on `lp_exit` returns `lp_state` to 0 in the next cycle, and after that a new request is accepted.
- R12: If a local request and a received request primitive arrive in the same idle cycle, the local request wins and no indication is raised.
- R13: At most one of `up_granted`, `up_rejected` and `up_timeout` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upper layers ask to enter low power |
| up_req_deep | input | 1 | Requested state: 0 shallow, 1 deep |
| up_dec_valid | input | 1 | Upper-layer decision on an indicated request |
| up_dec_accept | input | 1 | Decision: 1 accept, 0 reject |
| lp_exit | input | 1 | Wake logic asks to leave the low-power state |
| rx_valid | input | 1 | A primitive was received |
| rx_prim | input | 3 | Received primitive code |
| tx_valid | output | 1 | Ask the PHY to send a primitive this cycle |
| tx_prim | output | 3 | Primitive code to send |
| up_ind_valid | output | 1 | One-cycle pulse: far end asked for low power |
| up_ind_deep | output | 1 | State the far end asked for |
| up_granted | output | 1 | One-cycle pulse: local request accepted |
| up_rejected | output | 1 | One-cycle pulse: local request rejected |
| up_timeout | output | 1 | One-cycle pulse: local request timed out |
| lp_state | output | 2 | Interface state: 0 active, 1 shallow, 2 deep |

## Verification
The bound checker enforces, on every cycle:
- the outcome pulses are exclusive;
- transmission stops right after a reply is seen during a request;
- a grant comes with a non-active state;
- nothing is sent while in low power;
- every reply burst is exactly `REPLY_COUNT` long;
- a timeout follows exactly `TIMEOUT_CYCLES` request cycles.

Only the bench scenarios can show that:
- the right flavour code is sent and reported;
- stray requests during a handshake or in low power leave everything unchanged;
- a same-cycle collision goes to the local side;
- `lp_exit` makes the block usable again.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int PRIM_W = 3;

  typedef enum logic [PRIM_W-1:0] {
    PRIM_NONE        = 3'd0,
    PRIM_REQ_SHALLOW = 3'd1,
    PRIM_REQ_DEEP    = 3'd2,
    PRIM_ACCEPT      = 3'd3,
    PRIM_REJECT      = 3'd4
  } prim_e;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_REQUEST,
    HS_AWAIT_DECISION,
    HS_REPLY,
    HS_LOW
  } hs_state_e;

  typedef enum logic [1:0] {
    LP_ACTIVE  = 2'd0,
    LP_SHALLOW = 2'd1,
    LP_DEEP    = 2'd2
  } lp_e;

  function automatic prim_e request_code(input logic deep);
    return deep ? PRIM_REQ_DEEP : PRIM_REQ_SHALLOW;
  endfunction

  function automatic prim_e reply_code(input logic accept);
    return accept ? PRIM_ACCEPT : PRIM_REJECT;
  endfunction

  function automatic logic is_request(input logic [PRIM_W-1:0] p);
    return (p == PRIM_REQ_SHALLOW) || (p == PRIM_REQ_DEEP);
  endfunction

  function automatic lp_e target_state(input logic deep);
    return deep ? LP_DEEP : LP_SHALLOW;
  endfunction
endpackage

// File: rtl/lpm_span_counter.sv
module lpm_span_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) count_q <= '0;
    else                count_q <= count_q + 1'b1;
  end

  // high in the LIMIT-th consecutive cycle of run
  assign last = run && (count_q == CW'(LIMIT - 1));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  input  logic              up_req_deep,
  input  logic              up_dec_valid,
  input  logic              up_dec_accept,
  input  logic              lp_exit,
  input  logic              rx_valid,
  input  logic [PRIM_W-1:0] rx_prim,
  input  logic              reply_done,
  input  logic              timer_expired,
  output hs_state_e         state,
  output logic              target_deep,
  output logic              accept_q,
  output logic              ind_pulse,
  output logic              granted_pulse,
  output logic              rejected_pulse,
  output logic              timeout_pulse
);
  logic rx_accept, rx_reject, rx_request;

  assign rx_accept  = rx_valid && (rx_prim == PRIM_ACCEPT);
  assign rx_reject  = rx_valid && (rx_prim == PRIM_REJECT);
  assign rx_request = rx_valid && is_request(rx_prim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= HS_IDLE;
      target_deep    <= 1'b0;
      accept_q       <= 1'b0;
      ind_pulse      <= 1'b0;
      granted_pulse  <= 1'b0;
      rejected_pulse <= 1'b0;
      timeout_pulse  <= 1'b0;
    end else begin
      ind_pulse      <= 1'b0;
      granted_pulse  <= 1'b0;
      rejected_pulse <= 1'b0;
      timeout_pulse  <= 1'b0;
      case (state)
        HS_IDLE: begin
          if (up_req_valid) begin
            state       <= HS_REQUEST;
            target_deep <= up_req_deep;
          end else if (rx_request) begin
            state       <= HS_AWAIT_DECISION;
            target_deep <= (rx_prim == PRIM_REQ_DEEP);
            ind_pulse   <= 1'b1;
          end
        end
        HS_REQUEST: begin
          if (rx_accept) begin
            state         <= HS_LOW;
            granted_pulse <= 1'b1;
          end else if (rx_reject) begin
            state          <= HS_IDLE;
            rejected_pulse <= 1'b1;
          end else if (timer_expired) begin
            state         <= HS_IDLE;
            timeout_pulse <= 1'b1;
          end
        end
        HS_AWAIT_DECISION: begin
          if (up_dec_valid) begin
            state    <= HS_REPLY;
            accept_q <= up_dec_accept;
          end
        end
        HS_REPLY: begin
          if (reply_done) state <= accept_q ? HS_LOW : HS_IDLE;
        end
        HS_LOW: begin
          if (lp_exit) state <= HS_IDLE;
        end
        default: state <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpm_handshake.sv
module lpm_handshake
  import lpm_pkg::*;
#(
  parameter int REPLY_COUNT    = 8,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_req_valid,
  input  logic       up_req_deep,
  input  logic       up_dec_valid,
  input  logic       up_dec_accept,
  input  logic       lp_exit,
  input  logic       rx_valid,
  input  logic [2:0] rx_prim,
  output logic       tx_valid,
  output logic [2:0] tx_prim,
  output logic       up_ind_valid,
  output logic       up_ind_deep,
  output logic       up_granted,
  output logic       up_rejected,
  output logic       up_timeout,
  output logic [1:0] lp_state
);
  if (REPLY_COUNT < 4 || REPLY_COUNT > 16) begin : g_bad_reply_count
    $error("REPLY_COUNT must lie in 4..16");
  end

  hs_state_e state;
  logic      target_deep, accept_q;
  logic      requesting, replying, reply_done, timer_expired;

  assign requesting = (state == HS_REQUEST);
  assign replying   = (state == HS_REPLY);

  lpm_span_counter #(.LIMIT(REPLY_COUNT)) reply_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (replying),
    .last  (reply_done)
  );

  if (TIMEOUT_CYCLES > 0) begin : g_timer
    lpm_span_counter #(.LIMIT(TIMEOUT_CYCLES)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (requesting),
      .last  (timer_expired)
    );
  end else begin : g_no_timer
    assign timer_expired = 1'b0;
  end

  lpm_fsm fsm_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .up_req_valid   (up_req_valid),
    .up_req_deep    (up_req_deep),
    .up_dec_valid   (up_dec_valid),
    .up_dec_accept  (up_dec_accept),
    .lp_exit        (lp_exit),
    .rx_valid       (rx_valid),
    .rx_prim        (rx_prim),
    .reply_done     (reply_done),
    .timer_expired  (timer_expired),
    .state          (state),
    .target_deep    (target_deep),
    .accept_q       (accept_q),
    .ind_pulse      (up_ind_valid),
    .granted_pulse  (up_granted),
    .rejected_pulse (up_rejected),
    .timeout_pulse  (up_timeout)
  );

  always_comb begin
    tx_valid = 1'b0;
    tx_prim  = PRIM_NONE;
    if (requesting) begin
      tx_valid = 1'b1;
      tx_prim  = request_code(target_deep);
    end else if (replying) begin
      tx_valid = 1'b1;
      tx_prim  = reply_code(accept_q);
    end
  end

  assign up_ind_deep = target_deep;
  assign lp_state    = (state == HS_LOW) ? target_state(target_deep) : LP_ACTIVE;
endmodule

// File: rtl/lpm_handshake_chk.sv
module lpm_handshake_chk
  import lpm_pkg::*;
#(
  parameter int REPLY_COUNT    = 8,
  parameter int TIMEOUT_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic [2:0] tx_prim,
  input logic       rx_valid,
  input logic [2:0] rx_prim,
  input logic       up_granted,
  input logic       up_rejected,
  input logic       up_timeout,
  input logic [1:0] lp_state
);
  logic req_on, reply_on, reply_seen;
  int   req_len, reply_len;

  assign req_on     = tx_valid && is_request(tx_prim);
  assign reply_on   = tx_valid && (tx_prim == PRIM_ACCEPT || tx_prim == PRIM_REJECT);
  assign reply_seen = rx_valid && (rx_prim == PRIM_ACCEPT || rx_prim == PRIM_REJECT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_len   <= 0;
      reply_len <= 0;
    end else begin
      req_len   <= req_on   ? req_len + 1   : 0;
      reply_len <= reply_on ? reply_len + 1 : 0;
    end
  end

  // R13
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_granted, up_rejected, up_timeout}));

  // R3
  stop_on_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_on && reply_seen) |=> !tx_valid);

  // R4
  grant_lowpower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_granted |-> (lp_state != LP_ACTIVE));

  // R10
  quiet_lowpower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state != LP_ACTIVE) |-> !tx_valid);

  // R8
  reply_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_on |-> (reply_len < REPLY_COUNT));

  // R8
  reply_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reply_on && reply_len != 0) |-> (reply_len == REPLY_COUNT));

  // R6
  timeout_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_timeout |-> (TIMEOUT_CYCLES > 0 && req_len == TIMEOUT_CYCLES));
endmodule

bind lpm_handshake lpm_handshake_chk #(
  .REPLY_COUNT    (REPLY_COUNT),
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_valid    (tx_valid),
  .tx_prim     (tx_prim),
  .rx_valid    (rx_valid),
  .rx_prim     (rx_prim),
  .up_granted  (up_granted),
  .up_rejected (up_rejected),
  .up_timeout  (up_timeout),
  .lp_state    (lp_state)
);

// File: tb/lpm_handshake_tb_top.sv
module lpm_handshake_tb_top;
  localparam int RC = 8;
  localparam int TO = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_req_valid = 1'b0, up_req_deep = 1'b0;
  logic       up_dec_valid = 1'b0, up_dec_accept = 1'b0;
  logic       lp_exit = 1'b0, rx_valid = 1'b0;
  logic [2:0] rx_prim = 3'd0;
  logic       tx_valid, up_ind_valid, up_ind_deep;
  logic       up_granted, up_rejected, up_timeout;
  logic [2:0] tx_prim;
  logic [1:0] lp_state;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lpm_handshake #(.REPLY_COUNT(RC), .TIMEOUT_CYCLES(TO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(up_req_valid), .up_req_deep(up_req_deep),
    .up_dec_valid(up_dec_valid), .up_dec_accept(up_dec_accept),
    .lp_exit(lp_exit), .rx_valid(rx_valid), .rx_prim(rx_prim),
    .tx_valid(tx_valid), .tx_prim(tx_prim),
    .up_ind_valid(up_ind_valid), .up_ind_deep(up_ind_deep),
    .up_granted(up_granted), .up_rejected(up_rejected),
    .up_timeout(up_timeout), .lp_state(lp_state)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int req_code(input logic deep);
    return deep ? 2 : 1;
  endfunction

  task automatic t_reset();
    check("R1 tx_valid", tx_valid, 0);
    check("R1 lp_state", lp_state, 0);
    check("R1 outcome pulses", {up_granted, up_rejected, up_timeout}, 0);
    check("R1 up_ind_valid", up_ind_valid, 0);
  endtask

  task automatic t_init_accept(input logic deep);
    up_req_valid = 1'b1; up_req_deep = deep; step(); up_req_valid = 1'b0;
    check("R2 tx_valid", tx_valid, 1);
    check("R2 tx_prim", tx_prim, req_code(deep));
    for (int i = 0; i < 3; i++) begin
      step();
      check("R2 repeated request", {tx_valid, tx_prim}, {1'b1, 3'(req_code(deep))});
    end
    up_req_valid = 1'b1; up_req_deep = !deep; step(); up_req_valid = 1'b0;
    check("R10 request while busy", tx_prim, req_code(deep));
    rx_valid = 1'b1; rx_prim = 3'd3; step(); rx_valid = 1'b0;
    check("R3 stop after accept", tx_valid, 0);
    check("R4 granted pulse", up_granted, 1);
    check("R4 lp_state", lp_state, req_code(deep));
    step();
    check("R4 granted single cycle", up_granted, 0);
    check("R4 lp_state held", lp_state, req_code(deep));
    up_req_valid = 1'b1; step(); up_req_valid = 1'b0;
    check("R10 request in low power tx", tx_valid, 0);
    check("R10 request in low power state", lp_state, req_code(deep));
    lp_exit = 1'b1; step(); lp_exit = 1'b0;
    check("R11 exit to active", lp_state, 0);
  endtask

  task automatic t_init_reject();
    up_req_valid = 1'b1; up_req_deep = 1'b0; step(); up_req_valid = 1'b0;
    check("R11 new request after exit", tx_valid, 1);
    rx_valid = 1'b1; rx_prim = 3'd4; step(); rx_valid = 1'b0;
    check("R3 stop after reject", tx_valid, 0);
    check("R5 rejected pulse", up_rejected, 1);
    check("R5 lp_state", lp_state, 0);
    check("R13 no grant with reject", up_granted, 0);
    step();
    check("R5 rejected single cycle", up_rejected, 0);
  endtask

  task automatic t_timeout();
    int bad = 0;
    up_req_valid = 1'b1; up_req_deep = 1'b1; step(); up_req_valid = 1'b0;
    rx_valid = 1'b1; rx_prim = 3'd1;
    for (int k = 1; k <= TO; k++) begin
      if (!(tx_valid && tx_prim == 3'd2) || up_ind_valid || up_timeout) bad++;
      if (k < TO) step();
    end
    check("R6 request held for whole window", bad, 0);
    step(); rx_valid = 1'b0;
    check("R6 timeout pulse", up_timeout, 1);
    check("R6 tx stops", tx_valid, 0);
    check("R10 rx request ignored while requesting", up_ind_valid, 0);
    step();
    check("R6 timeout single cycle", up_timeout, 0);
  endtask

  task automatic t_responder(input logic deep, input logic accept, input int dly);
    int n = 0;
    int bad = 0;
    rx_valid = 1'b1; rx_prim = 3'(req_code(deep)); step();
    check("R7 indication pulse", up_ind_valid, 1);
    check("R7 indication flavour", up_ind_deep, deep);
    for (int i = 0; i < dly; i++) begin
      up_req_valid = 1'b1;
      step();
      check("R7 no repeat indication", up_ind_valid, 0);
      check("R10 no tx while awaiting decision", tx_valid, 0);
    end
    up_req_valid = 1'b0; rx_valid = 1'b0;
    up_dec_valid = 1'b1; up_dec_accept = accept; step(); up_dec_valid = 1'b0;
    while (tx_valid && n < 40) begin
      if (tx_prim != (accept ? 3'd3 : 3'd4)) bad++;
      n++;
      step();
    end
    check("R8 reply count", n, RC);
    check("R8 reply code", bad, 0);
    check("R9 state after reply", lp_state, accept ? req_code(deep) : 0);
    if (accept) begin
      lp_exit = 1'b1; step(); lp_exit = 1'b0;
      check("R11 exit after responder entry", lp_state, 0);
    end
  endtask

  task automatic t_collision();
    up_req_valid = 1'b1; up_req_deep = 1'b0;
    rx_valid = 1'b1; rx_prim = 3'd2;
    step(); up_req_valid = 1'b0; rx_valid = 1'b0;
    check("R12 local request wins", {tx_valid, tx_prim}, {1'b1, 3'd1});
    check("R12 no indication", up_ind_valid, 0);
    rx_valid = 1'b1; rx_prim = 3'd4; step(); rx_valid = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1; step();
    t_reset();
    t_init_accept(1'b0);
    t_init_accept(1'b1);
    t_init_reject();
    t_timeout();
    t_responder(1'b1, 1'b1, 2);
    t_responder(1'b0, 1'b0, 0);
    t_responder(1'b0, 1'b1, 5);
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule